// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading a three-level page table held in memory. A request carries the virtual address, the kind of access (read, write or execute), the privilege level and the base of the first-level table. The walker fetches one descriptor per level and uses its two-bit type field to decide whether to continue, stop at a leaf or fault. A leaf can be found at any level. A leaf found above the last level maps a large region, and the low virtual address bits pass straight through.

At the leaf the walker checks the access against a 3-bit permission code. The check depends on whether the request is user or supervisor. On success it sets the referenced flag, and for a write it also sets the modified flag. If either flag changes, it stores the updated descriptor back with a single memory write, then answers with the physical address and the cacheable flag. A failed walk answers with a fault kind and the level reached, and it writes nothing to memory. Only one walk is in progress at a time. The memory port carries one 32-bit word per access and holds each request until it is acknowledged.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address splits into a level-1 index in bits 31:24, a level-2 index in bits 23:18, a level-3 index in bits 17:12 and a page offset in bits 11:0. The level-1 entry is read at `{req_root,6'b0} + 4*index1`. A pointer descriptor word W gives the next table base `{W[31:2],6'b0}`, and the next entry is read at that base plus 4 times the next index.
- R2: The type field of a descriptor is its bits 1:0. The codes are 0 invalid, 1 pointer to the next table, 2 leaf, and 3 reserved.
- R3: For a leaf at level 3, `rsp_paddr = {W[31:8],12'b0} | VA[11:0]` and `rsp_cacheable = W[7]`.
- R4: A leaf at level 1 gives a physical address whose bits 23:0 come from the virtual address. A leaf at level 2 gives a physical address whose bits 17:0 come from the virtual address. In both cases the remaining high bits come from `{W[31:8],12'b0}`.
- R5: The leaf access code is W[4:2]. `req_kind` is 0 for read, 1 for write and 2 for execute. For a user request (`req_super`=0), read is allowed by codes 0, 1, 2, 3 and 5, write by codes 1 and 3, and execute by codes 2, 3 and 4. For a supervisor request, read is allowed by every code except 4, write by codes 1, 3, 5 and 7, and execute by codes 2, 3, 4, 6 and 7. Any other combination is a permission fault.
- R6: A successful walk sets bit 5 (referenced) of the leaf, and a successful write also sets bit 6 (modified). The updated word is written once, to the address the leaf was read from, and only when it differs from the word that was read.
- R7: A faulting walk issues no memory write.
- R8: A fault answers with `rsp_fault`=1 and a `rsp_ftype` code: 0 for an invalid entry, 1 for the reserved type, 2 for a pointer found at level 3, and 3 for a permission fault. `rsp_level` gives the level (1 to 3) of the descriptor that ended the walk.
- R9: `req_ready` stays low from the accepted request until the response handshake. A response, and a memory request, holds its values until it is accepted.
- R10: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_super | input | 1 | Supervisor privilege |
| req_root | input | 30 | Level-1 table base, physical bits 35:6 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response accepted |
| rsp_paddr | output | 36 | Translated physical address |
| rsp_cacheable | output | 1 | Cacheable flag of the leaf |
| rsp_fault | output | 1 | Walk failed |
| rsp_ftype | output | 2 | Fault kind |
| rsp_level | output | 2 | Level that ended the walk |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 36 | Byte address of the descriptor |
| mem_wdata | output | 32 | Descriptor write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Descriptor read data |

## Verification
On every cycle, the assertions check that the handshakes hold their values, that `req_ready` stays low while a response waits, and that every write-back word is a leaf with its referenced bit set. They also check that a write-back is always followed by a successful response and that every fault reports a nonzero level. Only the bench scenarios can show that the walker visits the correct table entries and composes the correct physical address for each leaf depth. The bench also covers the full permission table for every access kind and privilege level, and checks that writes occur exactly when a flag changes and never on a fault.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int DESC_W = 32;
    localparam int VA_W   = 32;
    localparam int PA_W   = 36;
    localparam int OFF_W  = 12;
    localparam int IX1_W  = 8;
    localparam int IX2_W  = 6;
    localparam int IX3_W  = 6;
    localparam int LVL1_KEEP = OFF_W + IX3_W + IX2_W;
    localparam int LVL2_KEEP = OFF_W + IX3_W;
    localparam int BIT_CACHE = 7;
    localparam int BIT_MOD   = 6;
    localparam int BIT_REF   = 5;

    typedef enum logic [1:0] {ET_INVALID = 2'd0, ET_PTD = 2'd1, ET_PTE = 2'd2, ET_RESV = 2'd3} etype_t;
    typedef enum logic [1:0] {K_READ = 2'd0, K_WRITE = 2'd1, K_EXEC = 2'd2} kind_t;
    typedef enum logic [1:0] {F_INVALID = 2'd0, F_RESERVED = 2'd1, F_DEPTH = 2'd2, F_PERM = 2'd3} fault_t;
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WBACK, S_RESP} state_t;

    typedef struct packed {
        state_t              st;
        logic [VA_W-1:0]     va;
        logic [1:0]          kind;
        logic                sup;
        logic [1:0]          lvl;
        logic [PA_W-1:0]     addr;
        logic [DESC_W-1:0]   word;
        logic [PA_W-1:0]     pa;
        logic                cach;
        logic                flt;
        fault_t              ftype;
    } walk_t;
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm (
    input  logic [2:0] acc,
    input  logic [1:0] kind,
    input  logic       sup,
    output logic       ok
);
    import ptw_pkg::*;
    logic rd, wr, ex;

    always_comb begin
        if (sup) begin
            rd = (acc != 3'd4);
            wr = acc[0] && (acc != 3'd1 ? acc[2] || acc[1] : 1'b1);
            ex = acc[1] || (acc == 3'd4);
        end else begin
            rd = (acc inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5});
            wr = (acc inside {3'd1, 3'd3});
            ex = (acc inside {3'd2, 3'd3, 3'd4});
        end
        unique case (kind)
            K_READ:  ok = rd;
            K_WRITE: ok = wr;
            K_EXEC:  ok = ex;
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptw_leaf_addr.sv
module ptw_leaf_addr (
    input  logic [ptw_pkg::DESC_W-9:0] ppn,
    input  logic [ptw_pkg::VA_W-1:0]   va,
    input  logic [1:0]                 lvl,
    output logic [ptw_pkg::PA_W-1:0]   pa
);
    import ptw_pkg::*;
    localparam logic [PA_W-1:0] ONE = {{(PA_W-1){1'b0}}, 1'b1};
    logic [PA_W-1:0] base, keep;
    logic [PA_W-1:0] va_ext;

    always_comb begin
        base   = {ppn, {OFF_W{1'b0}}};
        va_ext = {{(PA_W-VA_W){1'b0}}, va};
        unique case (lvl)
            2'd1:    keep = (ONE << LVL1_KEEP) - ONE;
            2'd2:    keep = (ONE << LVL2_KEEP) - ONE;
            default: keep = (ONE << OFF_W) - ONE;
        endcase
        pa = (base & ~keep) | (va_ext & keep);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic        req_super,
    input  logic [29:0] req_root,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [35:0] rsp_paddr,
    output logic        rsp_cacheable,
    output logic        rsp_fault,
    output logic [1:0]  rsp_ftype,
    output logic [1:0]  rsp_level,
    output logic        mem_valid,
    output logic        mem_we,
    output logic [35:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    import ptw_pkg::*;

    walk_t q, d;
    logic            perm_ok;
    logic [PA_W-1:0] leaf_pa;
    logic [DESC_W-1:0] upd_word;

    function automatic logic [PA_W-1:0] entry_off(input logic [1:0] lvl, input logic [VA_W-1:0] va);
        unique case (lvl)
            2'd1:    entry_off = {{(PA_W-IX1_W-2){1'b0}}, va[VA_W-1 -: IX1_W], 2'b00};
            2'd2:    entry_off = {{(PA_W-IX2_W-2){1'b0}}, va[VA_W-IX1_W-1 -: IX2_W], 2'b00};
            default: entry_off = {{(PA_W-IX3_W-2){1'b0}}, va[OFF_W+IX3_W-1 -: IX3_W], 2'b00};
        endcase
    endfunction

    ptw_perm u_perm (
        .acc  (mem_rdata[4:2]),
        .kind (q.kind),
        .sup  (q.sup),
        .ok   (perm_ok)
    );

    ptw_leaf_addr u_leaf (
        .ppn (mem_rdata[DESC_W-1:8]),
        .va  (q.va),
        .lvl (q.lvl),
        .pa  (leaf_pa)
    );

    always_comb begin
        d = q;
        upd_word = mem_rdata;
        upd_word[BIT_REF] = 1'b1;
        if (q.kind == K_WRITE) upd_word[BIT_MOD] = 1'b1;

        unique case (q.st)
            S_IDLE: if (req_valid) begin
                d.va    = req_vaddr;
                d.kind  = req_kind;
                d.sup   = req_super;
                d.lvl   = 2'd1;
                d.addr  = {req_root, 6'b0} + entry_off(2'd1, req_vaddr);
                d.flt   = 1'b0;
                d.ftype = F_INVALID;
                d.pa    = '0;
                d.cach  = 1'b0;
                d.st    = S_FETCH;
            end
            S_FETCH: if (mem_ack) begin
                unique case (etype_t'(mem_rdata[1:0]))
                    ET_INVALID: begin
                        d.flt = 1'b1; d.ftype = F_INVALID; d.st = S_RESP;
                    end
                    ET_RESV: begin
                        d.flt = 1'b1; d.ftype = F_RESERVED; d.st = S_RESP;
                    end
                    ET_PTD: begin
                        if (q.lvl == 2'd3) begin
                            d.flt = 1'b1; d.ftype = F_DEPTH; d.st = S_RESP;
                        end else begin
                            d.lvl  = q.lvl + 2'd1;
                            d.addr = {mem_rdata[DESC_W-1:2], 6'b0} + entry_off(q.lvl + 2'd1, q.va);
                        end
                    end
                    default: begin
                        if (!perm_ok) begin
                            d.flt = 1'b1; d.ftype = F_PERM; d.st = S_RESP;
                        end else begin
                            d.word = upd_word;
                            d.pa   = leaf_pa;
                            d.cach = mem_rdata[BIT_CACHE];
                            d.st   = (upd_word != mem_rdata) ? S_WBACK : S_RESP;
                        end
                    end
                endcase
            end
            S_WBACK: if (mem_ack) d.st = S_RESP;
            default: if (rsp_ready) d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.ftype <= F_INVALID;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == S_IDLE);
    assign rsp_valid     = (q.st == S_RESP);
    assign rsp_paddr     = q.pa;
    assign rsp_cacheable = q.cach;
    assign rsp_fault     = q.flt;
    assign rsp_ftype     = q.ftype;
    assign rsp_level     = q.lvl;
    assign mem_valid     = (q.st == S_FETCH) || (q.st == S_WBACK);
    assign mem_we        = (q.st == S_WBACK);
    assign mem_addr      = q.addr;
    assign mem_wdata     = q.word;

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_valid) |-> !req_ready);
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_ftype));
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
    assert_wb_leaf_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[BIT_REF] && (mem_wdata[1:0] == 2'b10));
    assert_wb_then_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && mem_ack |=> rsp_valid && !rsp_fault);
    assert_fault_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_level != 2'd0);
endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic [29:0] req_root = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [35:0] rsp_paddr;
    logic        rsp_cacheable, rsp_fault;
    logic [1:0]  rsp_ftype, rsp_level;
    logic        mem_valid, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0, errors = 0;
    int wr_count = 0;
    logic [35:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    logic [31:0] mem_a [longint];
    logic        done = 1'b0;

    localparam logic [35:0] L1_BASE = 36'h0_0001_0000;
    localparam logic [35:0] L2_BASE = 36'h0_0002_0000;
    localparam logic [35:0] L3_BASE = 36'h0_0003_0000;
    localparam logic [31:0] VA = {8'h12, 6'h05, 6'h3A, 12'h345};
    localparam logic [35:0] A1 = L1_BASE + 36'h48;
    localparam logic [35:0] A2 = L2_BASE + 36'h14;
    localparam logic [35:0] A3 = L3_BASE + 36'hE8;

    always #2 clk = ~clk;

    ptw_walker dut (.*);

    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_valid && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem_a[longint'(mem_addr >> 2)] = mem_wdata;
                wr_count++;
                last_wr_addr = mem_addr;
                last_wr_data = mem_wdata;
            end else begin
                last_rd_addr = mem_addr;
                mem_rdata <= mem_a.exists(longint'(mem_addr >> 2)) ? mem_a[longint'(mem_addr >> 2)] : 32'h0;
            end
        end else mem_ack <= 1'b0;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ptd(input logic [35:0] base);
        return {base[35:6], 2'b01};
    endfunction

    function automatic logic [31:0] pte(input logic [35:0] pa, input logic [7:0] flags, input logic [2:0] acc);
        return {pa[35:12], flags[7:5], acc, 2'b10};
    endfunction

    function automatic bit allowed(input logic [2:0] acc, input int kind, input bit sup);
        logic [2:0] rwx;
        case ({sup, acc})
            4'h0: rwx = 3'b100; 4'h1: rwx = 3'b110; 4'h2: rwx = 3'b101; 4'h3: rwx = 3'b111;
            4'h4: rwx = 3'b001; 4'h5: rwx = 3'b100; 4'h6: rwx = 3'b000; 4'h7: rwx = 3'b000;
            4'h8: rwx = 3'b100; 4'h9: rwx = 3'b110; 4'hA: rwx = 3'b101; 4'hB: rwx = 3'b111;
            4'hC: rwx = 3'b001; 4'hD: rwx = 3'b110; 4'hE: rwx = 3'b101; default: rwx = 3'b111;
        endcase
        return rwx[2 - kind];
    endfunction

    task automatic tree(input logic [31:0] w1, w2, w3);
        mem_a[longint'(A1 >> 2)] = w1;
        mem_a[longint'(A2 >> 2)] = w2;
        mem_a[longint'(A3 >> 2)] = w3;
    endtask

    task automatic walk(input logic [31:0] va, input int kind, input bit sup, input int hold,
                        output int writes);
        int wr0 = wr_count;
        int busy_bad = 0;
        logic [35:0] pa0;
        @(negedge clk);
        req_vaddr = va; req_kind = 2'(kind); req_super = sup; req_root = L1_BASE[35:6];
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) begin
            if (req_ready) busy_bad++;
            @(negedge clk);
        end
        pa0 = rsp_paddr;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (req_ready || !rsp_valid || rsp_paddr != pa0) busy_bad++;
        end
        chk(busy_bad == 0, "R9 busy/hold", 64'(busy_bad), 64'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        writes = wr_count - wr0;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R10 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(mem_valid == 1'b0, "R10 mem_valid", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_read_l3();
        int w;
        logic [35:0] exp = 36'h9_ABCD_E345;
        tree(ptd(L2_BASE), ptd(L3_BASE), pte(36'h9_ABCD_E000, 8'h80, 3'd0));
        walk(VA, 0, 1'b0, 0, w);
        chk(!rsp_fault && rsp_paddr == exp, "R3 paddr", 64'(rsp_paddr), 64'(exp));
        chk(rsp_cacheable == 1'b1, "R3 cacheable", 64'(rsp_cacheable), 64'd1);
        chk(last_rd_addr == A3, "R1 entry addr", 64'(last_rd_addr), 64'(A3));
        chk(w == 1 && last_wr_addr == A3, "R6 one write", 64'(w), 64'd1);
        chk(last_wr_data == pte(36'h9_ABCD_E000, 8'hA0, 3'd0), "R6 ref set",
            64'(last_wr_data), 64'(pte(36'h9_ABCD_E000, 8'hA0, 3'd0)));
        walk(VA, 0, 1'b0, 3, w);
        chk(w == 0, "R6 no write when unchanged", 64'(w), 64'd0);
    endtask

    task automatic t_write();
        int w;
        tree(ptd(L2_BASE), ptd(L3_BASE), pte(36'h7_0000_1000, 8'h00, 3'd1));
        walk(VA, 1, 1'b1, 0, w);
        chk(!rsp_fault && rsp_cacheable == 1'b0, "R3 write ok uncached", 64'(rsp_fault), 64'd0);
        chk(w == 1 && last_wr_data == pte(36'h7_0000_1000, 8'h60, 3'd1), "R6 ref+mod",
            64'(last_wr_data), 64'(pte(36'h7_0000_1000, 8'h60, 3'd1)));
    endtask

    task automatic t_perm_sweep();
        int w;
        for (int a = 0; a < 8; a++)
            for (int k = 0; k < 3; k++)
                for (int s = 0; s < 2; s++) begin
                    bit exp_ok = allowed(3'(a), k, s[0]);
                    tree(ptd(L2_BASE), ptd(L3_BASE), pte(36'h1_2340_0000, 8'h00, 3'(a)));
                    walk(VA, k, s[0], 0, w);
                    if (exp_ok)
                        chk(!rsp_fault && w == 1, "R5 allowed", 64'(rsp_fault), 64'd0);
                    else
                        chk(rsp_fault && rsp_ftype == 2'd3 && rsp_level == 2'd3 && w == 0,
                            "R5/R7 denied", {rsp_fault, rsp_ftype, rsp_level, 32'(w)}, {1'b1, 2'd3, 2'd3, 32'd0});
                end
    endtask

    task automatic t_faults();
        int w;
        tree(ptd(L2_BASE), 32'h0, 32'h0);
        walk(VA, 0, 1'b1, 0, w);
        chk(rsp_fault && rsp_ftype == 2'd0 && rsp_level == 2'd2 && w == 0, "R2/R8 invalid L2",
            {rsp_ftype, rsp_level}, {2'd0, 2'd2});
        tree(32'h0000_0003, 32'h0, 32'h0);
        walk(VA, 0, 1'b1, 0, w);
        chk(rsp_fault && rsp_ftype == 2'd1 && rsp_level == 2'd1 && w == 0, "R2/R8 reserved L1",
            {rsp_ftype, rsp_level}, {2'd1, 2'd1});
        tree(ptd(L2_BASE), ptd(L3_BASE), ptd(36'h0_0004_0000));
        walk(VA, 0, 1'b1, 0, w);
        chk(rsp_fault && rsp_ftype == 2'd2 && rsp_level == 2'd3 && w == 0, "R8/R7 pointer at L3",
            {rsp_ftype, rsp_level}, {2'd2, 2'd3});
    endtask

    task automatic t_large();
        int w;
        logic [35:0] exp;
        tree(pte(36'h5_6000_0000, 8'hA0, 3'd3), 32'h0, 32'h0);
        walk(VA, 2, 1'b0, 0, w);
        exp = 36'h5_6000_0000 | {12'h0, VA[23:0]};
        chk(!rsp_fault && rsp_paddr == exp && rsp_level == 2'd1 && w == 0, "R4 L1 large page",
            64'(rsp_paddr), 64'(exp));
        tree(ptd(L2_BASE), pte(36'h3_00C0_0000, 8'h20, 3'd1), 32'h0);
        walk(VA, 0, 1'b0, 2, w);
        exp = 36'h3_00C0_0000 | {18'h0, VA[17:0]};
        chk(!rsp_fault && rsp_paddr == exp && rsp_level == 2'd2, "R4 L2 large page",
            64'(rsp_paddr), 64'(exp));
        chk(last_rd_addr == A2, "R1 L2 entry addr", 64'(last_rd_addr), 64'(A2));
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_l3();
        t_write();
        t_faults();
        t_large();
        t_perm_sweep();
        done = 1'b1;
        finish_up();
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end
endmodule